// File: doc/BRIEF.md
# Timed Register Trigger Sequencer

This block plays back a host-prepared table of byte pairs against one parallel port register to produce hand-timed waveforms on the port pins. Each pair holds two bytes: a value to drive into the register, then a hold time in microseconds. For every pair, in table order, the block issues a one-cycle register write strobe carrying the value. It then holds for the given time before it fetches the next pair.

The host fills the table memory, then pulses start together with a register select and a byte length. The table is read through a synchronous read port with one cycle of latency. A free-standing prescaler, sized from a clock-frequency parameter, turns the system clock into microsecond ticks. The prescaler restarts at every hold, so each hold lasts an exact whole number of clock cycles. When the final hold of the sequence has run out, the block raises a one-cycle done pulse.

Top module: `trig_seq`

## Requirements
- R1: Table byte 2i holds the value of pair i and byte 2i+1 holds its hold time. Each pair produces exactly one write strobe, one cycle wide, that carries the value and the register select latched at start.
- R2: Pairs are played in increasing address order, and each write comes before its hold. While a strobe is high, the table address output is odd and points at that pair's hold byte.
- R3: Two consecutive strobes are 3 + d*C clock cycles apart, where d is the hold byte of the earlier pair and C = CLK_HZ/1000000 cycles per microsecond.
- R4: A hold byte of 255 gives the longest hold, 255 microseconds (255*C cycles added to the spacing).
- R5: A hold byte of 0 adds no wait, so the next strobe follows 3 cycles after the previous one.
- R6: The length input counts bytes. The number of strobes is floor(length/2), and an odd final byte is never played.
- R7: A start with a length below 2 produces no strobe, and done pulses in the cycle after the start cycle.
- R8: The first strobe appears 3 cycles after the cycle in which start is high.
- R9: Done is a single one-cycle pulse per accepted start. It appears 1 + d*C cycles after the last strobe, where d is the last hold byte, and it is never high together with a strobe.
- R10: A start while a sequence is running is ignored. No extra strobes appear, and the register select stays at the value latched at the first start.
- R11: While reset is asserted and right after it, the strobe and done outputs are low and the table address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| reg_sel_i | input | REG_W | Target register select, latched at start |
| len_i | input | ADDR_W+1 | Table length in bytes |
| tbl_addr_o | output | ADDR_W | Table read address |
| tbl_data_i | input | 8 | Table read data, one cycle after the address |
| wr_en_o | output | 1 | Register write strobe |
| wr_reg_o | output | REG_W | Register selected for the write |
| wr_data_o | output | 8 | Value written to the register |
| done_o | output | 1 | One-cycle pulse after the final hold |

## Verification
A wrong pair count or address step shows up as a wrong value on the next strobe, or as a strobe too many or too few. The comparison of each strobe against the expected stream catches it within one pair. A hold timer or prescaler that is off by even one cycle moves every later strobe and the done pulse, and the check on absolute cycle numbers reports this at the first strobe after the faulty hold. A start that is not ignored while busy shows up at once as an unexpected strobe or a changed register select.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_FETCH = 3'd1,
        SQ_WRITE = 3'd2,
        SQ_HOLD  = 3'd3,
        SQ_WAIT  = 3'd4
    } sq_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/trig_us_tick.sv
module trig_us_tick #(
    parameter int CYC_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CNT_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_PER_US - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == LAST);
        if (clr_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/trig_hold_timer.sv
module trig_hold_timer
    import trig_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_val_i,
    input  logic              tick_i,
    output logic              expire_o
);
    logic [BYTE_W-1:0] left_d, left_q;

    always_comb begin
        expire_o = tick_i && (left_q == BYTE_W'(1));
        left_d   = left_q;
        if (load_i)                        left_d = load_val_i;
        else if (tick_i && left_q != '0)   left_d = left_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end
endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import trig_seq_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int ADDR_W = 8,
    parameter int REG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REG_W-1:0]  reg_sel_i,
    input  logic [ADDR_W:0]   len_i,
    output logic [ADDR_W-1:0] tbl_addr_o,
    input  logic [7:0]        tbl_data_i,
    output logic              wr_en_o,
    output logic [REG_W-1:0]  wr_reg_o,
    output logic [7:0]        wr_data_o,
    output logic              done_o
);
    localparam int CYC_PER_US = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;

    typedef struct packed {
        sq_state_e         state;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] pairs;
        logic [REG_W-1:0]  rsel;
        logic              wr_en;
        logic [7:0]        wr_data;
        logic              done;
    } sq_regs_t;

    sq_regs_t q, n;

    logic              hold_load;
    logic              pair_end;
    logic              us_tick;
    logic              hold_expire;
    logic [ADDR_W-1:0] pairs_in;

    assign pairs_in = len_i[ADDR_W:1];

    trig_us_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (hold_load),
        .tick_o (us_tick)
    );

    trig_hold_timer u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (hold_load),
        .load_val_i (tbl_data_i),
        .tick_i     (us_tick),
        .expire_o   (hold_expire)
    );

    always_comb begin
        n         = q;
        n.wr_en   = 1'b0;
        n.done    = 1'b0;
        hold_load = 1'b0;
        pair_end  = 1'b0;
        unique case (q.state)
            SQ_IDLE: begin
                if (start_i) begin
                    if (pairs_in == '0) begin
                        n.done = 1'b1;
                    end else begin
                        n.state = SQ_FETCH;
                        n.addr  = '0;
                        n.pairs = pairs_in;
                        n.rsel  = reg_sel_i;
                    end
                end
            end
            SQ_FETCH: begin
                n.addr  = q.addr + 1'b1;
                n.state = SQ_WRITE;
            end
            SQ_WRITE: begin
                n.wr_en   = 1'b1;
                n.wr_data = tbl_data_i;
                n.state   = SQ_HOLD;
            end
            SQ_HOLD: begin
                if (tbl_data_i == 8'd0) begin
                    pair_end = 1'b1;
                end else begin
                    hold_load = 1'b1;
                    n.state   = SQ_WAIT;
                end
            end
            SQ_WAIT: begin
                if (hold_expire) pair_end = 1'b1;
            end
            default: n.state = SQ_IDLE;
        endcase

        if (pair_end) begin
            if (q.pairs == ADDR_W'(1)) begin
                n.state = SQ_IDLE;
                n.done  = 1'b1;
            end else begin
                n.pairs = q.pairs - 1'b1;
                n.addr  = q.addr + 1'b1;
                n.state = SQ_FETCH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign tbl_addr_o = q.addr;
    assign wr_en_o    = q.wr_en;
    assign wr_reg_o   = q.rsel;
    assign wr_data_o  = q.wr_data;
    assign done_o     = q.done;
endmodule

module trig_seq_chk
    import trig_seq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int REG_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              done,
    input logic [ADDR_W-1:0] tbl_addr,
    input logic [REG_W-1:0]  wr_reg,
    input sq_state_e         st
);
    // R1
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R2
    strobe_odd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> tbl_addr[0]);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && wr_en));

    // R10
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != SQ_IDLE && $past(st) != SQ_IDLE) |-> $stable(wr_reg));

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!wr_en && !done && tbl_addr == '0));
endmodule

bind trig_seq trig_seq_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_o),
    .done     (done_o),
    .tbl_addr (tbl_addr_o),
    .wr_reg   (wr_reg_o),
    .st       (q.state)
);

// File: tb/trig_seq_test.sv
module trig_seq_test;
    localparam int CLK_HZ = 50_000_000;
    localparam int ADDR_W = 8;
    localparam int REG_W  = 2;
    localparam int C      = CLK_HZ / 1_000_000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [REG_W-1:0]  reg_sel = '0;
    logic [ADDR_W:0]   len = '0;
    logic [ADDR_W-1:0] tbl_addr;
    logic [7:0]        tbl_data;
    logic              wr_en;
    logic [REG_W-1:0]  wr_reg;
    logic [7:0]        wr_data;
    logic              done;

    logic [7:0] mem [0:(1<<ADDR_W)-1];

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    string cur_tag = "R1";

    int exp_cyc[$];
    int exp_val[$];
    int exp_reg[$];
    int done_cyc[$];

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc      <= cyc + 1;
        tbl_data <= mem[tbl_addr];
    end

    trig_seq #(.CLK_HZ(CLK_HZ), .ADDR_W(ADDR_W), .REG_W(REG_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .reg_sel_i  (reg_sel),
        .len_i      (len),
        .tbl_addr_o (tbl_addr),
        .tbl_data_i (tbl_data),
        .wr_en_o    (wr_en),
        .wr_reg_o   (wr_reg),
        .wr_data_o  (wr_data),
        .done_o     (done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor: pops expected strobes and done pulses
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (exp_cyc.size() == 0) begin
                chk(1'b0, "R6/R10 unexpected strobe", cyc, -1);
            end else begin
                int ec, ev, er;
                ec = exp_cyc.pop_front();
                ev = exp_val.pop_front();
                er = exp_reg.pop_front();
                chk(cyc == ec, {"R3 strobe cycle ", cur_tag}, cyc, ec);
                chk(int'(wr_data) == ev, {"R1 strobe value ", cur_tag}, wr_data, ev);
                chk(int'(wr_reg) == er, {"R10 strobe register ", cur_tag}, wr_reg, er);
            end
        end
        if (rst_n && done) begin
            if (done_cyc.size() == 0) begin
                chk(1'b0, "R9 unexpected done", cyc, -1);
            end else begin
                int dc;
                dc = done_cyc.pop_front();
                chk(cyc == dc, {"R9 done cycle ", cur_tag}, cyc, dc);
            end
        end
    end

    // driver: start a run and push the expected stream
    task automatic launch(input int rsel, input int nbytes);
        int s, t, last, np;
        @(negedge clk);
        s       = cyc;
        start   = 1'b1;
        reg_sel = REG_W'(rsel);
        len     = (ADDR_W+1)'(nbytes);
        np      = nbytes / 2;
        t       = s + 3;
        last    = s + 1;
        for (int i = 0; i < np; i++) begin
            exp_cyc.push_back(t);
            exp_val.push_back(int'(mem[2*i]));
            exp_reg.push_back(rsel);
            last = t + 1 + int'(mem[2*i+1]) * C;
            t    = t + 3 + int'(mem[2*i+1]) * C;
        end
        done_cyc.push_back(last);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        while (done_cyc.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(exp_cyc.size() == 0, {"R6 strobes left ", cur_tag}, exp_cyc.size(), 0);
    endtask

    task automatic put(input int idx, input int val, input int dly);
        mem[2*idx]   = 8'(val);
        mem[2*idx+1] = 8'(dly);
    endtask

    initial begin
        for (int i = 0; i < (1<<ADDR_W); i++) mem[i] = 8'hEE;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!wr_en, "R11 strobe in reset", wr_en, 0);
        chk(!done, "R11 done in reset", done, 0);
        chk(tbl_addr == '0, "R11 address in reset", tbl_addr, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!wr_en && !done, "R11 quiet after reset", {wr_en, done}, 0);

        // R2 R5 R8 mixed holds
        cur_tag = "R2/R5/R8";
        put(0, 8'hA5, 2); put(1, 8'h3C, 0); put(2, 8'h81, 1);
        launch(1, 6);
        wait_end();

        // R6 odd length drops last byte
        cur_tag = "R6";
        put(0, 8'h11, 1); put(1, 8'h22, 0); mem[4] = 8'h99;
        launch(0, 5);
        wait_end();

        // R7 short lengths
        cur_tag = "R7";
        launch(2, 1);
        wait_end();
        launch(3, 0);
        wait_end();

        // R10 start while busy ignored
        cur_tag = "R10";
        put(0, 8'h5A, 3); put(1, 8'hC3, 1);
        launch(2, 4);
        repeat (20) @(negedge clk);
        start = 1'b1; reg_sel = 2'd3; len = 9'd2;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end();

        // R4 longest hold
        cur_tag = "R4";
        put(0, 8'hFF, 255);
        launch(3, 2);
        wait_end();

        // R5 run of zero holds
        cur_tag = "R5 burst";
        for (int i = 0; i < 10; i++) put(i, i * 7 + 1, 0);
        launch(1, 20);
        wait_end();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule